// File: doc/BRIEF.md
# Nametable Row Interleave Address Logic

This block sits between a tile-based video processor's memory bus and the video RAM that holds the nametables. It watches the background pattern fetches and remembers bit 2 of the address, which tells whether the tile row being drawn lies in the upper or lower four pixel rows of the tile. On the next nametable fetch it uses that bit as the RAM's horizontal nametable-select line. Groups of four pixel rows therefore alternate between two side-by-side nametables with no processor involvement, which yields tiles that are effectively four pixels tall.

A two-bit control register written by the CPU picks one of three mappings. Plain pass-through is the reset default. The row interleave is the second. The third folds video A11 onto RAM A10, for boards that fit only two nametables. Video A11 is never altered, so a board with four nametables of RAM gets two interleaved pairs, and software chooses between them through the ordinary scroll registers.

The first nametable fetch of each line comes after a sprite pattern fetch, so its selection may be wrong. This is expected. Software hides that column by blanking the leftmost eight pixels.

Top module: `nt_row_interleave`

## Requirements
- R1: After reset the row latch holds 0 and the control register holds 0, so the RAM address equals video address bits [11:0].
- R2: When the read strobe `vrd_ni` rises while video A13 is 0, video A2 is captured into the row latch. The latch updates on the third clock edge after the rise, and the address must stay stable until then.
- R3: The latch changes only on a rising edge of the strobe. Address changes while the strobe stays low have no effect. A rise while A13 is 1 captures nothing.
- R4: With control bit 0 (enable) set and control bit 1 (fold) clear, any access with A13 = 1 drives RAM A10 from the row latch.
- R5: Accesses with A13 = 0 always pass video A10 to RAM A10.
- R6: RAM A11 always equals video A11, and RAM bits [9:0] always equal video bits [9:0].
- R7: With the enable bit clear, RAM A10 equals video A10 for every access, whatever the fold bit holds.
- R8: With both enable and fold set, an access with A13 = 1 drives RAM A10 from video A11.
- R9: Nametable and attribute reads (A13 = 1, including offsets 0x3C0 to 0x3FF) leave the row latch unchanged.
- R10: Reads from either pattern table (A12 = 0 or 1) are captured alike, so a sprite pattern fetch also sets the latch.
- R11: A CPU write (`cpu_we_i` high for one clock) loads both control bits, and the new mapping applies from the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vaddr_i | input | AW (14) | Video address bus |
| vrd_ni | input | 1 | Video read strobe, active low, asynchronous to clk_i |
| cpu_we_i | input | 1 | Control register write enable |
| cpu_wdata_i | input | 2 | Control data: bit 0 enable, bit 1 fold |
| ram_addr_o | output | AW-2 (12) | Remapped video RAM address |

## Verification
The hardest case to reach is a strobe rise that must not capture. The bench holds the strobe low on a pattern address, moves the address across A2 while it is still low, and then moves it into the nametable region before releasing the strobe. The only visible trace of the latch is RAM A10 during a later nametable access, so every capture is read back that way with interleave enabled. A replayed per-line sequence of pattern and nametable fetches then confirms that the selected nametable follows bit 2 of the fine row over sixteen rows.

// File: rtl/nti_pkg.sv
`timescale 1ns/1ps
package nti_pkg;
  typedef struct packed {
    logic fold;  // bit 1
    logic en;    // bit 0
  } nti_cfg_t;

  typedef enum logic [1:0] {
    MAP_PASS       = 2'd0,
    MAP_FOLD       = 2'd1,
    MAP_INTERLEAVE = 2'd2
  } nti_map_e;
endpackage

// File: rtl/nti_strobe_sync.sv
`timescale 1ns/1ps
module nti_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_ni,
  output logic rise_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;  // idle strobe is high
    else         sync_q <= {sync_q[DEPTH-2:0], rd_ni};
  end

  assign rise_o = sync_q[STAGES-1] & ~sync_q[STAGES];
endmodule

// File: rtl/nti_row_latch.sv
`timescale 1ns/1ps
module nti_row_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic region_i,
  input  logic row_bit_i,
  output logic row_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  row_q_o <= 1'b0;
    else if (rise_i && !region_i) row_q_o <= row_bit_i;
  end
endmodule

// File: rtl/nti_cfg_reg.sv
`timescale 1ns/1ps
module nti_cfg_reg #(
  parameter int unsigned CFG_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output nti_pkg::nti_cfg_t cfg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= '0;
    else if (we_i) cfg_o <= nti_pkg::nti_cfg_t'(wdata_i);
  end
endmodule

// File: rtl/nti_addr_mux.sv
`timescale 1ns/1ps
module nti_addr_mux (
  input  nti_pkg::nti_cfg_t cfg_i,
  input  logic region_i,
  input  logic a10_i,
  input  logic a11_i,
  input  logic row_i,
  output logic a10_o
);
  import nti_pkg::*;

  nti_map_e map;

  always_comb begin
    map = MAP_PASS;
    if (cfg_i.en && region_i) map = cfg_i.fold ? MAP_FOLD : MAP_INTERLEAVE;
  end

  always_comb begin
    unique case (map)
      MAP_FOLD:       a10_o = a11_i;
      MAP_INTERLEAVE: a10_o = row_i;
      default:        a10_o = a10_i;
    endcase
  end
endmodule

// File: rtl/nt_row_interleave.sv
`timescale 1ns/1ps
module nt_row_interleave #(
  parameter int unsigned AW          = 14,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CFG_W       = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    vaddr_i,
  input  logic             vrd_ni,
  input  logic             cpu_we_i,
  input  logic [CFG_W-1:0] cpu_wdata_i,
  output logic [AW-3:0]    ram_addr_o
);
  localparam int unsigned ROW_BIT    = 2;
  localparam int unsigned H_SEL_BIT  = 10;
  localparam int unsigned V_SEL_BIT  = 11;
  localparam int unsigned REGION_BIT = AW - 1;
  localparam int unsigned RAM_AW     = AW - 2;

  logic              rd_rise;
  logic              row_q;
  logic              a10_sel;
  nti_pkg::nti_cfg_t cfg_q;
  logic              unused_vaddr;

  assign unused_vaddr = vaddr_i[AW-2];

  nti_strobe_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_ni  (vrd_ni),
    .rise_o (rd_rise)
  );

  nti_row_latch i_row (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (rd_rise),
    .region_i  (vaddr_i[REGION_BIT]),
    .row_bit_i (vaddr_i[ROW_BIT]),
    .row_q_o   (row_q)
  );

  nti_cfg_reg #(.CFG_W(CFG_W)) i_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cpu_we_i),
    .wdata_i (cpu_wdata_i),
    .cfg_o   (cfg_q)
  );

  nti_addr_mux i_mux (
    .cfg_i    (cfg_q),
    .region_i (vaddr_i[REGION_BIT]),
    .a10_i    (vaddr_i[H_SEL_BIT]),
    .a11_i    (vaddr_i[V_SEL_BIT]),
    .row_i    (row_q),
    .a10_o    (a10_sel)
  );

  always_comb begin
    ram_addr_o                = vaddr_i[RAM_AW-1:0];
    ram_addr_o[H_SEL_BIT]     = a10_sel;
  end
endmodule

// File: rtl/nti_checker.sv
`timescale 1ns/1ps
module nti_checker #(
  parameter int unsigned AW = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AW-1:0]     vaddr_i,
  input logic [AW-3:0]     ram_addr_i,
  input nti_pkg::nti_cfg_t cfg_i,
  input logic              rise_i,
  input logic              row_i
);
  logic region;
  logic unused_chk;
  assign region     = vaddr_i[AW-1];
  assign unused_chk = vaddr_i[AW-2];

  always @(posedge clk_i)
    if (!rst_ni) a_r1_reset_state: assert (row_i == 1'b0 && cfg_i == '0);

  a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !region) |=> row_i == $past(vaddr_i[2]));

  a_r9_latch_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_i && !region) |=> $stable(row_i));

  a_r4_steer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.en && !cfg_i.fold && region) |-> ram_addr_i[10] == row_i);

  a_r5_pattern_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !region |-> ram_addr_i[10] == vaddr_i[10]);

  a_r6_untouched_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_addr_i[11] == vaddr_i[11] && ram_addr_i[9:0] == vaddr_i[9:0]);

  a_r7_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_i.en |-> ram_addr_i[10] == vaddr_i[10]);

  a_r8_fold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_i.en && cfg_i.fold && region) |-> ram_addr_i[10] == vaddr_i[11]);
endmodule

bind nt_row_interleave nti_checker #(.AW(AW)) i_nti_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vaddr_i    (vaddr_i),
  .ram_addr_i (ram_addr_o),
  .cfg_i      (cfg_q),
  .rise_i     (rd_rise),
  .row_i      (row_q)
);

// File: tb/test_nt_row_interleave.sv
`timescale 1ns/1ps
module test_nt_row_interleave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] vaddr = '0;
  logic        vrd_n = 1'b1;
  logic        we = 1'b0;
  logic [1:0]  wdata = '0;
  logic [11:0] ram_addr;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  nt_row_interleave i_nt_row_interleave (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .vaddr_i     (vaddr),
    .vrd_ni      (vrd_n),
    .cpu_we_i    (we),
    .cpu_wdata_i (wdata),
    .ram_addr_o  (ram_addr)
  );

  task automatic chk(input logic [11:0] act, input logic [11:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ram_addr actual %03h expected %03h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] with_a10(input logic [13:0] a, input logic b);
    logic [11:0] r;
    r = a[11:0];
    r[10] = b;
    return r;
  endfunction

  // drive an address without a read, then check the remapped output
  task automatic look(input logic [13:0] a, input logic exp10, input string req);
    @(negedge clk);
    vaddr = a;
    #1 chk(ram_addr, with_a10(a, exp10), req);
  endtask

  task automatic read_cycle(input logic [13:0] a);
    @(negedge clk);
    vaddr = a; vrd_n = 1'b0;
    repeat (2) @(negedge clk);
    vrd_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_cfg(input logic [1:0] v);
    @(negedge clk);
    we = 1'b1; wdata = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic t_reset;
    look(14'h2445, 1'b1, "R1 pass-through in reset");
    look(14'h2845, 1'b0, "R1 pass-through in reset");
    @(negedge clk); rst_n = 1'b1;
    look(14'h2445, 1'b1, "R1 pass-through after reset");
    write_cfg(2'b01);
    look(14'h2445, 1'b0, "R1 latch resets to 0 / R11 enable applies next cycle");
  endtask

  task automatic t_capture;
    read_cycle(14'h0125);
    look(14'h2045, 1'b1, "R2 capture A2=1 R4 steer");
    look(14'h2445, 1'b1, "R4 steer over video A10=1");
    read_cycle(14'h0123);
    look(14'h2445, 1'b0, "R2 capture A2=0 R4 steer");
  endtask

  task automatic t_edge_only;
    read_cycle(14'h0125);
    @(negedge clk);
    vaddr = 14'h0123; vrd_n = 1'b0;
    repeat (6) @(negedge clk);
    vaddr = 14'h2045;
    repeat (2) @(negedge clk);
    vrd_n = 1'b1;
    repeat (4) @(negedge clk);
    look(14'h2045, 1'b1, "R3 no capture without rise in pattern region");
  endtask

  task automatic t_attr;
    read_cycle(14'h0125);
    read_cycle(14'h23C0);
    read_cycle(14'h27F8);
    read_cycle(14'h2000);
    look(14'h2045, 1'b1, "R9 attribute and nametable reads keep latch");
  endtask

  task automatic t_pattern_pass;
    look(14'h0523, 1'b1, "R5 pattern A10=1 passes");
    look(14'h0123, 1'b0, "R5 pattern A10=0 passes");
  endtask

  task automatic t_a11;
    look(14'h2C45, 1'b1, "R6 A11 kept, A10 from latch");
    look(14'h2B7F, 1'b1, "R6 A11 and low bits kept");
  endtask

  task automatic t_disabled;
    write_cfg(2'b10);
    look(14'h2045, 1'b0, "R7 disabled A10=0 passes");
    look(14'h2445, 1'b1, "R7 disabled A10=1 passes");
    look(14'h2845, 1'b0, "R7 fold ignored when disabled");
  endtask

  task automatic t_fold;
    write_cfg(2'b11);
    look(14'h2845, 1'b1, "R8 fold A11 onto A10");
    look(14'h2445, 1'b0, "R8 fold A11=0");
    look(14'h0523, 1'b1, "R5 pattern passes in fold mode");
  endtask

  task automatic t_sprite;
    write_cfg(2'b01);
    read_cycle(14'h1004);
    look(14'h2000, 1'b1, "R10 sprite table capture A2=1");
    read_cycle(14'h1000);
    look(14'h2400, 1'b0, "R10 sprite table capture A2=0");
  endtask

  task automatic t_line;
    for (int row = 0; row < 16; row++) begin
      logic [13:0] pa;
      pa = 14'h0100 | 14'(row % 8);
      read_cycle(pa);
      look(14'h2000 | 14'(row), row[2], "R4 per-row interleave sequence");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_capture();
    t_edge_only();
    t_attr();
    t_pattern_pass();
    t_a11();
    t_disabled();
    t_fold();
    t_sprite();
    t_line();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule